// File: doc/BRIEF.md
# Chained Command Status and Interrupt Controller

This block sits between a processor command port and two packet engines, one for transmit and one for receive. Each channel keeps a two-slot queue of buffer page numbers. The processor can write two enable commands in a row. The block starts the engine on the oldest page and, when that operation completes, starts the next queued page without further processor action. The second start behaves as if its enable command had just been written.

Each completion produces a result: a done bit, and for transmit a success flag. Each channel can hold two results. The first is visible on the status outputs. The second is kept hidden until the processor clears the first with that channel's clear command. A single interrupt line reports the masked done bits. After it drops, it stays low for a programmable number of idle cycles before it can rise again. A cancel command removes the oldest queued transmit.

Top module: `chain_irq_ctrl`

## Requirements
- R1: When `cmd_valid` carries `cmd_op`=1 (transmit enqueue) and the transmit queue is empty, `tx_start` is high for exactly one cycle on the cycle after the command, and `tx_page` shows the command's page. No further start follows until a completion or a cancel.
- R2: A second transmit enqueue is held. When `tx_end` completes the running operation, `tx_start` pulses on the next cycle with the second page on `tx_page`.
- R3: A transmit completion sets `st_tx_done` on the next cycle, with `st_tx_ack` equal to `tx_end_ack`. `st_tx_ack` is never high while `st_tx_done` is low.
- R4: `st_tx_done` is cleared only by `cmd_op`=3 (transmit clear). Other commands, including `cmd_op`=4, leave it unchanged.
- R5: A completion that arrives while a result is still visible is held hidden. The transmit clear then shows the held result on the next cycle. While a result is held, no new start is issued; the start follows on the cycle after the clear.
- R6: `irq` is high on the cycle after `(st_tx_done & tx_irq_en) | (st_rx_done & rx_irq_en)` becomes true, provided no idle gap is running. The mask inputs gate only the interrupt and never the status bits.
- R7: Once `irq` falls, it stays low for at least GAP_CYCLES cycles. A clear that exposes a held result drops `irq` on the next cycle and raises it again after exactly GAP_CYCLES low cycles.
- R8: `cmd_op`=5 (transmit cancel) removes the oldest queued transmit, and the next queued page then starts. Two cancels empty the queue.
- R9: The receive channel behaves like the transmit channel. It uses `cmd_op`=2 to enqueue, `cmd_op`=4 to clear, and `rx_end` for completion. It has its own done bit, its own held second result and its own automatic second start.
- R10: An enqueue to a channel whose two slots are full is ignored, and `st_overflow` is set. It stays set until reset.
- R11: While reset is active, and on the first cycle after it, all outputs are low and both queues are empty.
- R12: A completion pulse with no started operation on that channel has no effect on status, `irq` or starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 1 tx enqueue, 2 rx enqueue, 3 tx clear, 4 rx clear, 5 tx cancel |
| cmd_page | input | PAGE_W | Page number carried by enqueue commands |
| tx_irq_en | input | 1 | Interrupt enable for the transmit done bit |
| rx_irq_en | input | 1 | Interrupt enable for the receive done bit |
| tx_end | input | 1 | Transmit engine completion pulse |
| tx_end_ack | input | 1 | Transmit success flag, qualified by `tx_end` |
| rx_end | input | 1 | Receive engine completion pulse |
| tx_start | output | 1 | One-cycle start strobe to the transmit engine |
| tx_page | output | PAGE_W | Page of the oldest queued transmit |
| rx_start | output | 1 | One-cycle start strobe to the receive engine |
| rx_page | output | PAGE_W | Page of the oldest queued receive |
| st_tx_done | output | 1 | Visible transmit result present |
| st_tx_ack | output | 1 | Success flag of the visible transmit result |
| st_rx_done | output | 1 | Visible receive result present |
| st_overflow | output | 1 | Sticky flag: an enqueue was dropped |
| irq | output | 1 | Interrupt request |

## Verification
Corrupted queue state shows at the start strobe. A wrong fill count or page slot either produces a start with the wrong page or fails to produce the start one cycle after the completion or command that should cause it. A mishandled held-result slot shows as a second done result leaking onto the status outputs before the clear, or as a start that is not blocked. A bad gap counter shows on the first re-assertion after a clear, because the number of low cycles is compared exactly against GAP_CYCLES.

// File: rtl/chain_irq_pkg.sv
package chain_irq_pkg;
    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_TX_ENQ    = 3'd1,
        OP_RX_ENQ    = 3'd2,
        OP_TX_CLR    = 3'd3,
        OP_RX_CLR    = 3'd4,
        OP_TX_CANCEL = 3'd5
    } cmd_op_e;
endpackage

// File: rtl/chan_queue.sv
// One channel: two-slot page queue, start gating and two result slots
// (one visible, one held).
module chan_queue #(
    parameter int unsigned PAGE_W  = 8,
    parameter bit          HAS_ACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_i,
    input  logic              clr_i,
    input  logic              cancel_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              end_i,
    input  logic              ack_i,
    output logic              start_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              done_o,
    output logic              ack_o,
    output logic              clr_hit_o,
    output logic              ovf_o
);
    localparam logic [1:0] SLOTS = 2'd2;

    typedef struct packed {
        logic [PAGE_W-1:0] pg_head;
        logic [PAGE_W-1:0] pg_next;
        logic [1:0]        fill;
        logic              busy;
        logic              shown;
        logic              shown_ack;
        logic              held;
        logic              held_ack;
        logic              start;
    } cq_state_t;

    cq_state_t st_d, st_q;
    logic      ack_bit;

    assign ack_bit = HAS_ACK ? ack_i : 1'b0;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        clr_hit_o  = 1'b0;
        ovf_o      = 1'b0;
        // clear first: the held result moves into view
        if (clr_i && st_q.shown) begin
            clr_hit_o      = 1'b1;
            st_d.shown     = st_d.held;
            st_d.shown_ack = st_d.held_ack;
            st_d.held      = 1'b0;
            st_d.held_ack  = 1'b0;
        end
        // completion of the running operation
        if (end_i && st_d.busy) begin
            st_d.busy    = 1'b0;
            st_d.pg_head = st_d.pg_next;
            st_d.fill    = st_d.fill - 2'd1;
            if (!st_d.shown) begin
                st_d.shown     = 1'b1;
                st_d.shown_ack = ack_bit;
            end else begin
                st_d.held     = 1'b1;
                st_d.held_ack = ack_bit;
            end
        end
        // cancel drops the oldest entry
        if (cancel_i && st_d.fill != 2'd0) begin
            st_d.busy    = 1'b0;
            st_d.pg_head = st_d.pg_next;
            st_d.fill    = st_d.fill - 2'd1;
        end
        if (enq_i) begin
            if (st_d.fill == SLOTS) begin
                ovf_o = 1'b1;
            end else if (st_d.fill == 2'd0) begin
                st_d.pg_head = page_i;
                st_d.fill    = 2'd1;
            end else begin
                st_d.pg_next = page_i;
                st_d.fill    = SLOTS;
            end
        end
        // launch when idle and a result slot is guaranteed free
        if (st_d.fill != 2'd0 && !st_d.busy && !st_d.held) begin
            st_d.busy  = 1'b1;
            st_d.start = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o = st_q.start;
    assign page_o  = st_q.pg_head;
    assign done_o  = st_q.shown;
    assign ack_o   = st_q.shown_ack;
endmodule

// File: rtl/irq_spacer.sv
// Registered interrupt with a minimum low interval after each drop.
module irq_spacer #(
    parameter int unsigned GAP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic clr_hit_i,
    output logic irq_o
);
    localparam int unsigned CW = $clog2(GAP_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] gap;
        logic          irq;
    } sp_state_t;

    sp_state_t sp_d, sp_q;
    logic      load;

    always_comb begin
        load = sp_q.irq && (clr_hit_i || !want_i);
        sp_d = sp_q;
        if (load)               sp_d.gap = CW'(GAP_CYCLES);
        else if (sp_q.gap != 0) sp_d.gap = sp_q.gap - 1'b1;
        sp_d.irq = want_i && (sp_d.gap == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    assign irq_o = sp_q.irq;
endmodule

// File: rtl/chain_irq_ctrl.sv
module chain_irq_ctrl
    import chain_irq_pkg::*;
#(
    parameter int unsigned PAGE_W     = 8,
    parameter int unsigned GAP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    input  logic              tx_end,
    input  logic              tx_end_ack,
    input  logic              rx_end,
    output logic              tx_start,
    output logic [PAGE_W-1:0] tx_page,
    output logic              rx_start,
    output logic [PAGE_W-1:0] rx_page,
    output logic              st_tx_done,
    output logic              st_tx_ack,
    output logic              st_rx_done,
    output logic              st_overflow,
    output logic              irq
);
    logic tx_enq, rx_enq, tx_clr, rx_clr, tx_cancel;
    logic tx_hit, rx_hit, tx_ovf, rx_ovf, rx_ack_nc;
    logic ovf_d, ovf_q, want;

    assign tx_enq    = cmd_valid && (cmd_op == OP_TX_ENQ);
    assign rx_enq    = cmd_valid && (cmd_op == OP_RX_ENQ);
    assign tx_clr    = cmd_valid && (cmd_op == OP_TX_CLR);
    assign rx_clr    = cmd_valid && (cmd_op == OP_RX_CLR);
    assign tx_cancel = cmd_valid && (cmd_op == OP_TX_CANCEL);

    chan_queue #(.PAGE_W(PAGE_W), .HAS_ACK(1'b1)) tx_ch_i (
        .clk(clk), .rst_n(rst_n), .enq_i(tx_enq), .clr_i(tx_clr),
        .cancel_i(tx_cancel), .page_i(cmd_page), .end_i(tx_end),
        .ack_i(tx_end_ack), .start_o(tx_start), .page_o(tx_page),
        .done_o(st_tx_done), .ack_o(st_tx_ack), .clr_hit_o(tx_hit),
        .ovf_o(tx_ovf)
    );

    chan_queue #(.PAGE_W(PAGE_W), .HAS_ACK(1'b0)) rx_ch_i (
        .clk(clk), .rst_n(rst_n), .enq_i(rx_enq), .clr_i(rx_clr),
        .cancel_i(1'b0), .page_i(cmd_page), .end_i(rx_end),
        .ack_i(1'b0), .start_o(rx_start), .page_o(rx_page),
        .done_o(st_rx_done), .ack_o(rx_ack_nc), .clr_hit_o(rx_hit),
        .ovf_o(rx_ovf)
    );

    always_comb begin
        ovf_d = ovf_q | tx_ovf | rx_ovf;
        want  = (st_tx_done & tx_irq_en) | (st_rx_done & rx_irq_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_d;
    end

    assign st_overflow = ovf_q;

    irq_spacer #(.GAP_CYCLES(GAP_CYCLES)) spacer_i (
        .clk(clk), .rst_n(rst_n), .want_i(want),
        .clr_hit_i(tx_hit | rx_hit), .irq_o(irq)
    );
endmodule

// File: rtl/chain_irq_ctrl_chk.sv
module chain_irq_ctrl_chk #(
    parameter int unsigned GAP_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       tx_irq_en,
    input logic       rx_irq_en,
    input logic       tx_start,
    input logic       rx_start,
    input logic       st_tx_done,
    input logic       st_tx_ack,
    input logic       st_rx_done,
    input logic       st_overflow,
    input logic       irq
);
    logic [15:0] low_run;
    logic        seen_high;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run   <= '0;
            seen_high <= 1'b0;
        end else if (irq) begin
            low_run   <= '0;
            seen_high <= 1'b1;
        end else if (low_run != 16'hFFFF) begin
            low_run <= low_run + 16'd1;
        end
    end

    AST_IRQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && seen_high && low_run != 16'd0) |-> (low_run >= 16'(GAP_CYCLES))); // R7
    AST_ACK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        st_tx_ack |-> st_tx_done); // R3
    AST_TX_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_tx_done && !(cmd_valid && cmd_op == 3'd3)) |=> st_tx_done); // R4
    AST_RX_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rx_done && !(cmd_valid && cmd_op == 3'd4)) |=> st_rx_done); // R9
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((st_tx_done && tx_irq_en) || (st_rx_done && rx_irq_en))); // R6
    AST_TX_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start); // R1
    AST_RX_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !rx_start); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_overflow |=> st_overflow); // R10
endmodule

bind chain_irq_ctrl chain_irq_ctrl_chk #(.GAP_CYCLES(GAP_CYCLES)) chk_i (.*);

// File: tb/chain_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module chain_irq_ctrl_tb_top;
    localparam int unsigned PW  = 8;
    localparam int unsigned GAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [PW-1:0] cmd_page = '0;
    logic tx_irq_en = 1'b0, rx_irq_en = 1'b0;
    logic tx_end = 1'b0, tx_end_ack = 1'b0, rx_end = 1'b0;
    logic tx_start, rx_start, st_tx_done, st_tx_ack, st_rx_done, st_overflow, irq;
    logic [PW-1:0] tx_page, rx_page;
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    chain_irq_ctrl #(.PAGE_W(PW), .GAP_CYCLES(GAP)) dut_i (.*);

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [PW-1:0] pg);
        cmd_valid = 1'b1; cmd_op = op; cmd_page = pg;
        cycle();
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic pulse_tx(input logic ok);
        tx_end = 1'b1; tx_end_ack = ok;
        cycle();
        tx_end = 1'b0; tx_end_ack = 1'b0;
    endtask

    task automatic pulse_rx();
        rx_end = 1'b1;
        cycle();
        rx_end = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic t_reset();
        check("R11 tx_start", tx_start, 0);
        check("R11 rx_start", rx_start, 0);
        check("R11 st_tx_done", st_tx_done, 0);
        check("R11 st_rx_done", st_rx_done, 0);
        check("R11 st_overflow", st_overflow, 0);
        check("R11 irq", irq, 0);
    endtask

    task automatic t_tx_chain();
        int lows;
        tx_irq_en = 1'b1;
        do_cmd(3'd1, 8'd5);
        check("R1 start", tx_start, 1);
        check("R1 page", tx_page, 5);
        do_cmd(3'd1, 8'd9);
        check("R1 single strobe", tx_start, 0);
        pulse_tx(1'b1);
        check("R3 done", st_tx_done, 1);
        check("R3 ack", st_tx_ack, 1);
        check("R2 auto start", tx_start, 1);
        check("R2 second page", tx_page, 9);
        check("R6 irq not yet", irq, 0);
        cycle();
        check("R6 irq", irq, 1);
        do_cmd(3'd4, 8'd0);
        check("R4 rx clear no effect", st_tx_done, 1);
        pulse_tx(1'b0);
        check("R5 second hidden ack", st_tx_ack, 1);
        do_cmd(3'd3, 8'd0);
        check("R5 shows held done", st_tx_done, 1);
        check("R5 shows held ack", st_tx_ack, 0);
        lows = 0;
        for (int i = 0; i < 20 && !irq; i++) begin
            lows++;
            cycle();
        end
        check("R7 gap low cycles", lows, GAP);
        do_cmd(3'd3, 8'd0);
        check("R4 clear", st_tx_done, 0);
        check("R4 clear ack", st_tx_ack, 0);
        check("R6 irq drops", irq, 0);
        idle(GAP + 2);
    endtask

    task automatic t_mask();
        tx_irq_en = 1'b0;
        do_cmd(3'd1, 8'd3);
        pulse_tx(1'b1);
        cycle();
        check("R6 masked status", st_tx_done, 1);
        check("R6 masked irq", irq, 0);
        tx_irq_en = 1'b1;
        cycle();
        check("R6 unmask irq", irq, 1);
        tx_irq_en = 1'b0;
        cycle();
        check("R6 remask irq", irq, 0);
        do_cmd(3'd3, 8'd0);
        tx_irq_en = 1'b1;
        idle(GAP + 2);
        check("R6 idle irq", irq, 0);
    endtask

    task automatic t_cancel();
        do_cmd(3'd1, 8'd11);
        check("R8 first start", tx_start, 1);
        do_cmd(3'd1, 8'd12);
        do_cmd(3'd5, 8'd0);
        check("R8 next start", tx_start, 1);
        check("R8 next page", tx_page, 12);
        do_cmd(3'd5, 8'd0);
        check("R8 empty no start", tx_start, 0);
        pulse_tx(1'b1);
        check("R12 stray end", st_tx_done, 0);
        check("R12 no start", tx_start, 0);
        cycle();
        check("R12 no irq", irq, 0);
    endtask

    task automatic t_overflow();
        do_cmd(3'd1, 8'd1);
        do_cmd(3'd1, 8'd2);
        check("R10 not yet", st_overflow, 0);
        do_cmd(3'd1, 8'd3);
        check("R10 flag", st_overflow, 1);
        pulse_tx(1'b1);
        check("R10 kept page", tx_page, 2);
        check("R10 start", tx_start, 1);
        pulse_tx(1'b0);
        check("R10 dropped page", tx_start, 0);
        do_cmd(3'd1, 8'd7);
        check("R5 start blocked", tx_start, 0);
        do_cmd(3'd3, 8'd0);
        check("R5 start after clear", tx_start, 1);
        check("R5 page after clear", tx_page, 7);
        check("R5 held ack", st_tx_ack, 0);
        pulse_tx(1'b1);
        do_cmd(3'd3, 8'd0);
        check("R5 third result", st_tx_ack, 1);
        do_cmd(3'd3, 8'd0);
        check("R4 final clear", st_tx_done, 0);
        check("R10 sticky", st_overflow, 1);
        idle(GAP + 2);
    endtask

    task automatic t_rx();
        int lows;
        rx_irq_en = 1'b1;
        do_cmd(3'd2, 8'd2);
        check("R9 rx start", rx_start, 1);
        check("R9 rx page", rx_page, 2);
        check("R9 tx untouched", tx_start, 0);
        do_cmd(3'd2, 8'd3);
        pulse_rx();
        check("R9 rx done", st_rx_done, 1);
        check("R9 rx auto start", rx_start, 1);
        check("R9 rx second page", rx_page, 3);
        cycle();
        check("R9 rx irq", irq, 1);
        pulse_rx();
        do_cmd(3'd3, 8'd0);
        check("R9 tx clear no effect", st_rx_done, 1);
        check("R9 irq stays", irq, 1);
        do_cmd(3'd4, 8'd0);
        check("R9 held shown", st_rx_done, 1);
        lows = 0;
        for (int i = 0; i < 20 && !irq; i++) begin
            lows++;
            cycle();
        end
        check("R7 rx gap", lows, GAP);
        do_cmd(3'd4, 8'd0);
        check("R9 rx cleared", st_rx_done, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        cycle();
        t_reset();
        t_tx_chain();
        t_mask();
        t_cancel();
        t_overflow();
        t_rx();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule